// File: doc/BRIEF.md
# Page Request Matcher with Per-Digit Care Masks

This block decides which received page headers the acquisition path should capture. A small request store holds eight page slots, split into two groups of four. Each slot holds seven 5-bit request words: one for the magazine and one for each of six digits (page tens, page units, hours tens, hours units, minutes tens, minutes units). Control software fills a slot by first loading a slot number and a start column. It then sends data words, and each word lands in the current column before the column pointer moves on.

Every request word carries a care bit, so a slot can ask for an exact page at an exact time, a page at any time, or anything from one magazine. When a decoded header arrives, the block compares it against the four slots of the selected group. The compare skips digits whose care bit is clear. It refuses any digit that is compared and arrived with a decoding error. One cycle later the block emits a single-cycle capture pulse that names the winning slot. Each slot also exposes a page-being-looked-for flag and an active-low page-found flag.

Top module: `page_req_match`

## Requirements
- R1: After reset, `cap_valid` is 0, `looking` is all zeros and `found_n` is all ones. Every request word resets to 0, so a header arriving before any request write produces no capture.
- R2: A `req_setup` cycle loads the slot pointer from `req_slot` and the column pointer from `req_col`. A `req_col` of 7 is taken as column 0. Each `req_valid` cycle without `req_setup` stores `req_word` at the pointed column and advances the column pointer. The pointer wraps from column 6 to column 0 within the same slot. A data word in the same cycle as `req_setup` is dropped.
- R3: The column numbering is 0 magazine, 1 page tens, 2 page units, 3 hours tens, 4 hours units, 5 minutes tens, 6 minutes units.
  - Column 0 holds the magazine in bits 2:0 and the hold bit in bit 3.
  - Columns 3 and 5 compare only bits 1:0 and bits 2:0 respectively.
  - The other digit columns compare bits 3:0.
  - A header matches a slot only when every compared digit is equal.
- R4: Bit 4 of every request word is the care bit. A digit with care 0 never prevents a match, so a slot whose care bits are all 0 and whose hold bit is 1 matches any header.
- R5: A slot whose hold bit (column 0 bit 3) is 0 never captures, and its `looking` and `found_n` flags are left unchanged by headers.
- R6: `hdr_err` bit c flags a decoding error in the digit of column c. An error on a digit with care 1 blocks the match for that slot. An error on a digit with care 0 is ignored.
- R7: Only slots whose index divided by four equals `acq_group` take part in matching. With the default size, `acq_group` 0 selects slots 0 to 3 and 1 selects slots 4 to 7.
- R8: A header on `hdr_valid` causes, on the following clock, either no pulse or exactly one single-cycle `cap_valid` pulse. When several slots match, `cap_slot` names the lowest-numbered one. `cap_valid` never rises without a header in the cycle before.
- R9: A captured slot drives `looking` low and `found_n` low on the same edge as its pulse, and both stay so until any data word is written into that slot. That write sets `looking` high and `found_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_setup | input | 1 | Load the request write pointer |
| req_slot | input | 3 | Slot for the pointer load |
| req_col | input | 3 | Start column for the pointer load |
| req_valid | input | 1 | Store one request word |
| req_word | input | 5 | Request word: care bit 4, value bits 3:0 |
| acq_group | input | 1 | Group of four slots used for matching |
| hdr_valid | input | 1 | Decoded header present this cycle |
| hdr_mag | input | 3 | Header magazine |
| hdr_pt | input | 4 | Header page tens |
| hdr_pu | input | 4 | Header page units |
| hdr_ht | input | 2 | Header hours tens |
| hdr_hu | input | 4 | Header hours units |
| hdr_mt | input | 3 | Header minutes tens |
| hdr_mu | input | 4 | Header minutes units |
| hdr_err | input | 7 | Per-column digit error flags |
| cap_valid | output | 1 | One-cycle capture pulse |
| cap_slot | output | 3 | Slot that captured |
| looking | output | 8 | Page-being-looked-for flag per slot |
| found_n | output | 8 | Active-low page-found flag per slot |

## Verification
The bench first checks column-pointer wrap and a start column of 7 by loading a slot from column 3 round to column 0, and by loading another slot from column 7. A design that wrapped wrongly would leave the magazine word unwritten, and matching on that slot would fail. A second group of checks covers several simultaneous matches, where a wrong priority shows up as the wrong `cap_slot`. The same group sends errors on cared and on ignored digits: a design that misread the error flags would either capture on corrupted headers or never capture on clean ones. The last checks cover a hold-bit-0 rewrite, a group switch and a pulse that lasts longer than one cycle. These show up as stray captures, flags that stay set after the rewrite, or `cap_valid` seen outside the cycle after a header.

// File: rtl/pgm_pkg.sv
// Shared constants and helpers for the page request matcher.
// Assumes the fixed seven-column request format: magazine plus six digits.
package pgm_pkg;
    localparam int NUM_COLS = 7;
    localparam int WORD_W   = 5;
    localparam int CARE_BIT = 4;
    localparam int HOLD_BIT = 3;
    localparam int DIG_W    = 4;
    localparam int COL_W    = $clog2(NUM_COLS);

    typedef logic [WORD_W-1:0] req_word_t;
    typedef logic [DIG_W-1:0]  digit_t;

    // Number of significant value bits compared in each column.
    function automatic int col_bits(input int col);
        case (col)
            0:       col_bits = 3;
            3:       col_bits = 2;
            5:       col_bits = 3;
            default: col_bits = 4;
        endcase
    endfunction
endpackage

// File: rtl/pgm_req_ram.sv
// Request store: NUM_SLOTS slots of NUM_COLS words, written through an
// auto-incrementing column pointer. A pointer load wins over a data word
// in the same cycle. Start columns past the last column map to column 0.
module pgm_req_ram
    import pgm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 set_ptr,
    input  logic [SLOT_W-1:0]                    set_slot,
    input  logic [COL_W-1:0]                     set_col,
    input  logic                                 wr_en,
    input  req_word_t                            wr_word,
    output logic [NUM_SLOTS-1:0][NUM_COLS-1:0][WORD_W-1:0] req,
    output logic [NUM_SLOTS-1:0]                 wr_oh
);
    logic [SLOT_W-1:0] slot_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_fire;

    assign wr_fire = wr_en && !set_ptr;

    // Pointer load and column advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            col_q  <= '0;
        end else if (set_ptr) begin
            slot_q <= set_slot;
            col_q  <= (set_col >= COL_W'(NUM_COLS)) ? '0 : set_col;
        end else if (wr_en) begin
            col_q  <= (col_q == COL_W'(NUM_COLS-1)) ? '0 : col_q + 1'b1;
        end
    end

    // Request word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else if (wr_fire) begin
            req[slot_q][col_q] <= wr_word;
        end
    end

    // One-hot marker of the slot written this cycle.
    always_comb begin
        wr_oh = '0;
        if (wr_fire) wr_oh[slot_q] = 1'b1;
    end

    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        col_q < COL_W'(NUM_COLS));
    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !set_ptr && col_q == COL_W'(NUM_COLS-1)) |=> col_q == '0);
endmodule

// File: rtl/pgm_slot_cmp.sv
// Compares one slot's request against a decoded header. A digit takes part
// only when its care bit is set; a compared digit with an error flag fails.
// The slot hits only with its hold bit set. Purely combinational; the clock
// serves the local assertions.
module pgm_slot_cmp
    import pgm_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_COLS-1:0][WORD_W-1:0]    req,
    input  logic [NUM_COLS-1:0][DIG_W-1:0]     dig,
    input  logic [NUM_COLS-1:0]                err,
    output logic                               hit
);
    logic [NUM_COLS-1:0] care;
    logic [NUM_COLS-1:0] pass;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam int        NB  = col_bits(c);
        localparam logic [DIG_W-1:0] MSK = DIG_W'((1 << NB) - 1);
        logic eq;
        // Masked digit equality for this column.
        assign eq      = ((req[c][DIG_W-1:0] ^ dig[c]) & MSK) == '0;
        assign care[c] = req[c][CARE_BIT];
        assign pass[c] = !care[c] || (eq && !err[c]);
    end

    assign hit = req[0][HOLD_BIT] && (&pass);

    p_err_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(care & err)) |-> !hit);
    p_hold_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req[0][HOLD_BIT] |-> !hit);
endmodule

// File: rtl/pgm_pick.sv
// Fixed-priority pick: lowest set index wins.
module pgm_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest index is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/page_req_match.sv
// Page request matcher top. Stores the request slots, compares each header
// against the slots of the selected group, and registers one capture pulse
// plus per-slot looking and found flags. Assumes headers arrive already
// decoded with one error flag per digit column.
module page_req_match
    import pgm_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int GROUP_SIZE = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int NUM_GRPS = NUM_SLOTS / GROUP_SIZE,
    localparam int GRP_W    = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_setup,
    input  logic [SLOT_W-1:0]    req_slot,
    input  logic [2:0]           req_col,
    input  logic                 req_valid,
    input  logic [4:0]           req_word,
    input  logic [GRP_W-1:0]     acq_group,
    input  logic                 hdr_valid,
    input  logic [2:0]           hdr_mag,
    input  logic [3:0]           hdr_pt,
    input  logic [3:0]           hdr_pu,
    input  logic [1:0]           hdr_ht,
    input  logic [3:0]           hdr_hu,
    input  logic [2:0]           hdr_mt,
    input  logic [3:0]           hdr_mu,
    input  logic [6:0]           hdr_err,
    output logic                 cap_valid,
    output logic [SLOT_W-1:0]    cap_slot,
    output logic [NUM_SLOTS-1:0] looking,
    output logic [NUM_SLOTS-1:0] found_n
);
    logic [NUM_SLOTS-1:0][NUM_COLS-1:0][WORD_W-1:0] req;
    logic [NUM_SLOTS-1:0]              wr_oh;
    logic [NUM_SLOTS-1:0]              hit;
    logic [NUM_SLOTS-1:0]              cand;
    logic [NUM_COLS-1:0][DIG_W-1:0]    dig;
    logic                              any_hit;
    logic [SLOT_W-1:0]                 win;
    logic                              fire;

    assign dig = {hdr_mu, 1'b0, hdr_mt, hdr_hu, 2'b00, hdr_ht,
                  hdr_pu, hdr_pt, 1'b0, hdr_mag};

    pgm_req_ram #(.NUM_SLOTS(NUM_SLOTS)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ptr  (req_setup),
        .set_slot (req_slot),
        .set_col  (req_col),
        .wr_en    (req_valid),
        .wr_word  (req_word),
        .req      (req),
        .wr_oh    (wr_oh)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        pgm_slot_cmp u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[i]),
            .dig   (dig),
            .err   (hdr_err),
            .hit   (hit[i])
        );
        assign cand[i] = hit[i] && (GRP_W'(i / GROUP_SIZE) == acq_group);

        p_found_needs_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(found_n[i]) |-> (cap_valid && cap_slot == SLOT_W'(i)));
    end

    pgm_pick #(.N(NUM_SLOTS)) u_pick (
        .req (cand),
        .any (any_hit),
        .idx (win)
    );

    assign fire = hdr_valid && any_hit;

    // Capture pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_slot  <= '0;
        end else begin
            cap_valid <= fire;
            if (fire) cap_slot <= win;
        end
    end

    // Per-slot flags: a write re-arms the slot, a capture marks it found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            looking <= '0;
            found_n <= '1;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (wr_oh[i]) begin
                    looking[i] <= 1'b1;
                    found_n[i] <= 1'b1;
                end else if (fire && win == SLOT_W'(i)) begin
                    looking[i] <= 1'b0;
                    found_n[i] <= 1'b0;
                end
            end
        end
    end

    p_cap_needs_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(hdr_valid));
    p_cap_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (GRP_W'(int'(cap_slot) / GROUP_SIZE) == $past(acq_group)));
    p_found_on_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !$past(req_valid)) |-> !found_n[cap_slot]);
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (looking & ~found_n) == '0);
endmodule

// File: tb/test_page_req_match.sv
`timescale 1ns/1ps
module test_page_req_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_setup = 1'b0;
    logic [2:0] req_slot = '0;
    logic [2:0] req_col = '0;
    logic       req_valid = 1'b0;
    logic [4:0] req_word = '0;
    logic [0:0] acq_group = '0;
    logic       hdr_valid = 1'b0;
    logic [2:0] hdr_mag = '0;
    logic [3:0] hdr_pt = '0, hdr_pu = '0, hdr_hu = '0, hdr_mu = '0;
    logic [1:0] hdr_ht = '0;
    logic [2:0] hdr_mt = '0;
    logic [6:0] hdr_err = '0;
    logic       cap_valid;
    logic [2:0] cap_slot;
    logic [7:0] looking, found_n;

    int checks = 0;
    int errors = 0;

    // Bench model of the request store and flags.
    logic [4:0] m_ram [8][7];
    int         m_slot = 0, m_col = 0, m_grp = 0;
    logic [7:0] m_look = '0, m_found_n = '1;
    logic [3:0] h_dig [7];
    logic [6:0] h_err;
    int         qs[$];
    string      qt[$];
    logic       hdr_seen = 1'b0;

    always #2 clk = ~clk;

    page_req_match i_page_req_match (
        .clk(clk), .rst_n(rst_n), .req_setup(req_setup), .req_slot(req_slot),
        .req_col(req_col), .req_valid(req_valid), .req_word(req_word),
        .acq_group(acq_group), .hdr_valid(hdr_valid), .hdr_mag(hdr_mag),
        .hdr_pt(hdr_pt), .hdr_pu(hdr_pu), .hdr_ht(hdr_ht), .hdr_hu(hdr_hu),
        .hdr_mt(hdr_mt), .hdr_mu(hdr_mu), .hdr_err(hdr_err),
        .cap_valid(cap_valid), .cap_slot(cap_slot), .looking(looking),
        .found_n(found_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] col_mask(input int c);
        case (c)
            0: col_mask = 4'h7;
            3: col_mask = 4'h3;
            5: col_mask = 4'h7;
            default: col_mask = 4'hF;
        endcase
    endfunction

    // Expected winner from the requirements: group, hold, care, error, priority.
    function automatic int exp_pick();
        for (int s = 0; s < 8; s++) begin
            bit ok;
            if (s / 4 != m_grp) continue;
            if (!m_ram[s][0][3]) continue;
            ok = 1'b1;
            for (int c = 0; c < 7; c++) begin
                if (m_ram[s][c][4]) begin
                    if (h_err[c]) ok = 1'b0;
                    else if (((m_ram[s][c][3:0] ^ h_dig[c]) & col_mask(c)) != 4'h0) ok = 1'b0;
                end
            end
            if (ok) return s;
        end
        return -1;
    endfunction

    task automatic set_ptr(input int s, input int c);
        @(negedge clk);
        req_setup = 1'b1; req_slot = 3'(s); req_col = 3'(c);
        m_slot = s; m_col = (c >= 7) ? 0 : c;
        @(negedge clk);
        req_setup = 1'b0;
    endtask

    task automatic put_word(input logic [4:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_word = w;
        m_ram[m_slot][m_col] = w;
        m_look[m_slot] = 1'b1; m_found_n[m_slot] = 1'b1;
        m_col = (m_col == 6) ? 0 : m_col + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_grp(input int g);
        @(negedge clk);
        acq_group = 1'(g); m_grp = g;
    endtask

    // Driver: drive one header and push the expected capture result.
    task automatic send_hdr(input int mag, input int pt, input int pu, input int ht,
                            input int hu, input int mt, input int mu,
                            input logic [6:0] err, input string tag);
        int e;
        @(negedge clk);
        h_dig[0] = 4'(mag); h_dig[1] = 4'(pt); h_dig[2] = 4'(pu); h_dig[3] = 4'(ht);
        h_dig[4] = 4'(hu);  h_dig[5] = 4'(mt); h_dig[6] = 4'(mu); h_err = err;
        e = exp_pick();
        qs.push_back(e); qt.push_back(tag);
        if (e >= 0) begin m_look[e] = 1'b0; m_found_n[e] = 1'b0; end
        hdr_valid = 1'b1; hdr_mag = 3'(mag); hdr_pt = 4'(pt); hdr_pu = 4'(pu);
        hdr_ht = 2'(ht); hdr_hu = 4'(hu); hdr_mt = 3'(mt); hdr_mu = 4'(mu); hdr_err = err;
        @(negedge clk);
        hdr_valid = 1'b0; hdr_err = '0;
    endtask

    task automatic chk_flags(input string tag);
        @(negedge clk);
        chk(looking == m_look, {tag, " looking"}, looking, m_look);
        chk(found_n == m_found_n, {tag, " found_n"}, found_n, m_found_n);
    endtask

    always @(posedge clk) hdr_seen <= hdr_valid;

    // Monitor: compare each capture result against the scoreboard.
    always @(negedge clk) begin
        if (hdr_seen && qs.size() > 0) begin
            int e;
            string t;
            e = qs.pop_front(); t = qt.pop_front();
            if (e < 0) chk(cap_valid == 1'b0, {t, " no capture"}, cap_valid, 0);
            else chk(cap_valid && cap_slot == 3'(e), {t, " capture slot"},
                     cap_valid ? int'(cap_slot) : -1, e);
        end else if (rst_n && cap_valid) begin
            chk(1'b0, "R8 stray pulse", 1, 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 7; c++) m_ram[s][c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and no capture from unwritten slots
        chk(cap_valid == 1'b0, "R1 cap_valid", cap_valid, 0);
        chk_flags("R1");
        send_hdr(0, 0, 0, 0, 0, 0, 0, 7'h00, "R1");

        // Slot 0: magazine 3, page 15, time don't-care
        set_ptr(0, 0);
        put_word(5'b11011); put_word(5'b10001); put_word(5'b10101);
        put_word(5'b00000); put_word(5'b00000); put_word(5'b00000); put_word(5'b00000);
        chk_flags("R9 armed");
        send_hdr(3, 1, 5, 0, 0, 0, 0, 7'h00, "R3 exact page");
        chk_flags("R9 found");
        send_hdr(3, 1, 6, 0, 0, 0, 0, 7'h00, "R3 units differ");
        send_hdr(2, 1, 5, 0, 0, 0, 0, 7'h00, "R3 magazine differs");
        send_hdr(3, 9, 5, 0, 0, 0, 0, 7'h00, "R3 tens differ");
        send_hdr(3, 1, 5, 3, 9, 7, 9, 7'h00, "R4 time ignored");
        send_hdr(3, 1, 5, 0, 0, 0, 0, 7'h04, "R6 cared digit error");
        send_hdr(3, 1, 5, 0, 0, 0, 0, 7'h08, "R6 ignored digit error");

        // Slot 1: start at column 3, wrap to magazine (timed page 12:34, mag 5)
        set_ptr(1, 3);
        put_word(5'b10001); put_word(5'b10010); put_word(5'b10011); put_word(5'b10100);
        put_word(5'b11101); put_word(5'b00000); put_word(5'b00000);
        send_hdr(5, 4, 2, 1, 2, 3, 4, 7'h00, "R2 wrapped write");
        send_hdr(5, 4, 2, 1, 2, 3, 5, 7'h00, "R3 minutes differ");
        send_hdr(5, 4, 2, 1, 3, 3, 4, 7'h00, "R3 hours differ");

        // Slot 2: match-anything slot
        set_ptr(2, 0);
        put_word(5'b01000);
        send_hdr(3, 1, 5, 0, 0, 0, 0, 7'h00, "R8 priority lowest");
        send_hdr(7, 0, 0, 0, 0, 0, 0, 7'h00, "R4 all dont-care");
        @(negedge clk);
        chk(cap_valid == 1'b0, "R8 single cycle", cap_valid, 0);

        // Slot 2 rewritten with hold 0
        set_ptr(2, 0);
        put_word(5'b10111);
        chk_flags("R9 rewrite");
        send_hdr(7, 0, 0, 0, 0, 0, 0, 7'h00, "R5 held slot");
        chk_flags("R5 flags kept");

        // Upper group
        set_grp(1);
        send_hdr(3, 1, 5, 0, 0, 0, 0, 7'h00, "R7 lower group excluded");
        set_ptr(5, 7);
        put_word(5'b11110);
        send_hdr(6, 0, 0, 0, 0, 0, 0, 7'h00, "R2 start column 7");
        set_ptr(4, 0);
        put_word(5'b01000);
        send_hdr(6, 0, 0, 0, 0, 0, 0, 7'h00, "R8 priority in group");
        send_hdr(3, 1, 5, 0, 0, 0, 0, 7'h00, "R7 upper group");
        set_grp(0);
        send_hdr(7, 0, 0, 0, 0, 0, 0, 7'h00, "R7 back to lower");
        chk_flags("R9 final");

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule